// File: doc/BRIEF.md
# Sampling Register with Hold

This block is a one-entry sampling stage between a producer and a consumer that both use valid/ready handshakes. The producer is never stalled: the input ready is always high, and every valid input is written into a single storage slot. A newer input replaces an older one even if the consumer never took the older one. This makes the block suitable for control values or status snapshots, where only the freshest value matters.

Three parameters shape its behaviour. `LATENCY` selects between a combinational bypass (0) and a registered capture (1). `REPLAY` chooses what happens after the consumer takes a value. When it is set, the value stays valid and is offered again on every cycle. When it is clear, the value is dropped once it has been taken. `HAS_INIT` with `INIT_VAL` lets the output leave reset already valid and carrying a known value. Reset is synchronous and active high.

Top module: `samp_reg`

## Requirements
- R1: Without a reset value (`HAS_INIT`=0), `out_valid` is low in the cycle after reset is released, as long as no input arrives.
- R2: With `HAS_INIT`=1, the cycle after reset shows `out_valid` high and `out_data` equal to `INIT_VAL`.
- R3: With `LATENCY`=1, an input presented in a cycle does not reach the output in that cycle. It appears at the output from the next cycle on.
- R4: With `LATENCY`=0, a valid input shows up on `out_valid`/`out_data` in the same cycle.
- R5: `in_ready` is always high. A valid input overwrites the stored value whether or not that value was consumed, so after back-to-back inputs only the last one is offered.
- R6: With `REPLAY`=1, a stored value stays valid after an output handshake. It is offered again on every later cycle until a new input replaces it.
- R7: With `REPLAY`=0, an output handshake with no input in the same cycle leaves the output invalid from the next cycle.
- R8: With `REPLAY`=0 and `LATENCY`=1, an input that arrives in the same cycle as an output handshake becomes the new stored value, and that value is valid in the next cycle.
- R9: With `LATENCY`=1, the output in a capture cycle still shows the value stored before that cycle's input.
- R10: With `LATENCY`=0, a stored value is offered when no input is present. When an input is present as well, the input takes precedence.
- R11: Reset acts only at a clock edge. Raising `rst` between edges does not change the output until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | DATA_W | Producer value |
| in_ready | output | 1 | Always high; input is never stalled |
| out_valid | output | 1 | A value is offered to the consumer |
| out_data | output | DATA_W | Offered value |
| out_ready | input | 1 | Consumer takes the offered value |

## Verification
Three configurations run side by side on the same stimulus: registered with drop, registered with replay and a reset value, and bypass with drop. A single input while the consumer is stalled separates the bypass path from the registered path, and it shows the old value during capture. Back-to-back inputs with no consumption expose any failure to overwrite. A take with no input, and a take together with a new input, separate replay from drop and show whether the new value survives the handshake. A reset raised between edges exposes an asynchronous reset.

// File: rtl/samp_pkg.sv
package samp_pkg;
   localparam int SAMP_LAT_MAX = 1;

   // valid bit kept in the slot after a cycle where a value may have been taken
   function automatic logic samp_keep(input logic replay, input logic taken);
      return replay | ~taken;
   endfunction
endpackage

// File: rtl/samp_slot.sv
module samp_slot #(
   parameter int                DATA_W   = 8,
   parameter bit                HAS_INIT = 1'b0,
   parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              q_valid,
   output logic [DATA_W-1:0] q_data
);
   localparam logic RST_VALID = HAS_INIT;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= RST_VALID;
         q_data  <= INIT_VAL;
      end else if (wr_en) begin
         q_valid <= wr_valid;
         q_data  <= wr_data;
      end
   end

   // R1 / R2: the slot leaves reset in the configured state
   assert_rstval_R1: assert property (@(posedge clk)
      rst |=> (q_valid == RST_VALID) && (q_data == INIT_VAL || !rst && $past(rst) == 1'b0));
endmodule

// File: rtl/samp_steer.sv
module samp_steer
   import samp_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LATENCY = 1,
   parameter bit REPLAY  = 1'b0
) (
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              out_ready,
   input  logic              q_valid,
   input  logic [DATA_W-1:0] q_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              wr_en,
   output logic              wr_valid,
   output logic [DATA_W-1:0] wr_data
);
   logic taken;

   if (LATENCY < 0 || LATENCY > SAMP_LAT_MAX) begin : g_bad_latency
      $error("samp_steer: LATENCY must be 0 or 1");
   end

   if (LATENCY == 0) begin : g_bypass
      always_comb begin
         out_valid = q_valid | in_valid;
         out_data  = in_valid ? in_data : q_data;
         taken     = out_valid & out_ready;
         wr_en     = in_valid | taken;
         wr_valid  = out_valid & samp_keep(REPLAY, taken);
         wr_data   = out_data;
      end
   end else begin : g_registered
      always_comb begin
         out_valid = q_valid;
         out_data  = q_data;
         taken     = out_valid & out_ready;
         wr_en     = in_valid | taken;
         wr_valid  = in_valid | samp_keep(REPLAY, taken);
         wr_data   = in_valid ? in_data : q_data;
      end
   end
endmodule

// File: rtl/samp_reg.sv
module samp_reg #(
   parameter int                DATA_W   = 8,
   parameter int                LATENCY  = 1,
   parameter bit                REPLAY   = 1'b0,
   parameter bit                HAS_INIT = 1'b0,
   parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);
   if (DATA_W < 1) begin : g_bad_width
      $error("samp_reg: DATA_W must be at least 1");
   end

   logic              q_valid, wr_en, wr_valid;
   logic [DATA_W-1:0] q_data, wr_data;

   assign in_ready = 1'b1;

   samp_steer #(.DATA_W(DATA_W), .LATENCY(LATENCY), .REPLAY(REPLAY)) u_steer (
      .in_valid (in_valid),
      .in_data  (in_data),
      .out_ready(out_ready),
      .q_valid  (q_valid),
      .q_data   (q_data),
      .out_valid(out_valid),
      .out_data (out_data),
      .wr_en    (wr_en),
      .wr_valid (wr_valid),
      .wr_data  (wr_data)
   );

   samp_slot #(.DATA_W(DATA_W), .HAS_INIT(HAS_INIT), .INIT_VAL(INIT_VAL)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .q_valid (q_valid),
      .q_data  (q_data)
   );

   // R5: every valid input lands in the slot
   assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> q_data == $past(in_data));

   if (LATENCY == 1) begin : g_chk_reg
      // R3: a registered output only becomes valid after an input
      assert_late_R3: assert property (@(posedge clk) disable iff (rst)
         $rose(out_valid) |-> $past(in_valid));
      // R9: the output in the next cycle equals the captured input
      assert_next_R9: assert property (@(posedge clk) disable iff (rst)
         in_valid |=> out_valid && out_data == $past(in_data));
      if (!REPLAY) begin : g_chk_load
         // R8
         assert_takeload_R8: assert property (@(posedge clk) disable iff (rst)
            in_valid && out_valid && out_ready |=> out_valid);
      end
   end else begin : g_chk_byp
      // R4: bypass presents the input in the same cycle
      assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
         in_valid |-> out_valid && out_data == in_data);
   end

   if (REPLAY) begin : g_chk_replay
      // R6
      assert_replay_R6: assert property (@(posedge clk) disable iff (rst)
         out_valid && out_ready |=> out_valid);
   end else begin : g_chk_drop
      // R7
      assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
         !in_valid && out_valid && out_ready |=> !q_valid);
   end
endmodule

// File: tb/samp_reg_tb.sv
module samp_reg_tb;
   localparam int DW = 8;
   localparam logic [DW-1:0] INIT_B = 8'h5A;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic out_ready = 1'b0;

   logic a_ir, a_ov, b_ir, b_ov, c_ir, c_ov;
   logic [DW-1:0] a_od, b_od, c_od;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   // registered, drop after take, no reset value
   samp_reg #(.DATA_W(DW), .LATENCY(1), .REPLAY(1'b0), .HAS_INIT(1'b0)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(a_ir),
      .out_valid(a_ov), .out_data(a_od), .out_ready(out_ready));
   // registered, replay, reset value
   samp_reg #(.DATA_W(DW), .LATENCY(1), .REPLAY(1'b1), .HAS_INIT(1'b1), .INIT_VAL(INIT_B)) u_hold (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(b_ir),
      .out_valid(b_ov), .out_data(b_od), .out_ready(out_ready));
   // bypass, drop after take
   samp_reg #(.DATA_W(DW), .LATENCY(0), .REPLAY(1'b0), .HAS_INIT(1'b0)) u_byp (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(c_ir),
      .out_valid(c_ov), .out_data(c_od), .out_ready(out_ready));

   task automatic chk(input string req, input string what, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at the falling edge, then let combinational paths settle
   task automatic drive(input logic r, input logic iv, input logic [DW-1:0] id, input logic rdy);
      @(negedge clk);
      rst = r; in_valid = iv; in_data = id; out_ready = rdy;
      #1;
   endtask

   task automatic t_reset;
      drive(1'b1, 1'b0, '0, 1'b0);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R1", "A valid after reset", a_ov, 1'b0);
      chk("R1", "C valid after reset", c_ov, 1'b0);
      chk("R2", "B valid after reset", b_ov, 1'b1);
      chk("R2", "B data after reset", b_od, INIT_B);
   endtask

   task automatic t_latency;
      drive(1'b0, 1'b1, 8'h11, 1'b0);
      chk("R3", "A valid in capture cycle", a_ov, 1'b0);
      chk("R4", "C valid same cycle", c_ov, 1'b1);
      chk("R4", "C data same cycle", c_od, 8'h11);
      chk("R9", "B shows old value", b_od, INIT_B);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R3", "A valid next cycle", a_ov, 1'b1);
      chk("R3", "A data next cycle", a_od, 8'h11);
      chk("R9", "B data next cycle", b_od, 8'h11);
      chk("R10", "C stored offered", c_od, 8'h11);
   endtask

   task automatic t_overwrite;
      drive(1'b0, 1'b1, 8'h22, 1'b0);
      chk("R5", "in_ready A", a_ir, 1'b1);
      drive(1'b0, 1'b1, 8'h33, 1'b0);
      chk("R5", "in_ready B", b_ir, 1'b1);
      chk("R5", "in_ready C", c_ir, 1'b1);
      chk("R9", "A shows prior during capture", a_od, 8'h22);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R5", "A last value", a_od, 8'h33);
      chk("R5", "B last value", b_od, 8'h33);
      chk("R5", "C last value", c_od, 8'h33);
   endtask

   task automatic t_take;
      drive(1'b0, 1'b0, '0, 1'b1);
      chk("R7", "A valid during take", a_ov, 1'b1);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R7", "A valid after take", a_ov, 1'b0);
      chk("R7", "C valid after take", c_ov, 1'b0);
      chk("R6", "B valid after take", b_ov, 1'b1);
      drive(1'b0, 1'b0, '0, 1'b1);
      drive(1'b0, 1'b0, '0, 1'b1);
      chk("R6", "B valid after repeated takes", b_ov, 1'b1);
      chk("R6", "B data replayed", b_od, 8'h33);
   endtask

   task automatic t_take_and_load;
      drive(1'b0, 1'b1, 8'h44, 1'b0);
      drive(1'b0, 1'b1, 8'h55, 1'b1);
      chk("R8", "A offers old during take", a_od, 8'h44);
      chk("R10", "C input wins over stored", c_od, 8'h55);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R8", "A valid after take with load", a_ov, 1'b1);
      chk("R8", "A data after take with load", a_od, 8'h55);
      chk("R7", "C dropped after bypass take", c_ov, 1'b0);
      chk("R6", "B holds new value", b_od, 8'h55);
   endtask

   task automatic t_bypass_stored;
      drive(1'b0, 1'b1, 8'h66, 1'b0);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R10", "C stored valid", c_ov, 1'b1);
      chk("R10", "C stored data", c_od, 8'h66);
      drive(1'b0, 1'b1, 8'h77, 1'b0);
      chk("R10", "C input over stored", c_od, 8'h77);
   endtask

   task automatic t_sync_reset;
      drive(1'b1, 1'b0, '0, 1'b0);
      chk("R11", "B data before edge", b_od, 8'h77);
      chk("R11", "A valid before edge", a_ov, 1'b1);
      drive(1'b0, 1'b0, '0, 1'b0);
      chk("R11", "B data after edge", b_od, INIT_B);
      chk("R11", "A valid after edge", a_ov, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_latency();
      t_overwrite();
      t_take();
      t_take_and_load();
      t_bypass_stored();
      t_sync_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule